// File: doc/BRIEF.md
# Card Clock Divider with Deferred Update

This block makes the clock that drives a memory card from the faster module clock. Software writes a clock control word that holds a divider, a run enable and a power-save flag. The divider and the enable do not take effect when they are written. They wait in a pending copy until software issues an update-only command.

The command sets a start flag that software can read back. The block copies the pending settings into the active ones only while the card clock is in its low phase, so no shortened pulse ever appears. It then clears the start flag and raises a one-cycle completion event for the interrupt logic.

If the command asks for it, the update is held off while a data transfer is active. With power-save set, the card clock stays low whenever no transfer is active.

The normal way to change frequency takes three updates in turn: stop the clock, change the divider, then start the clock again.

Top module: `card_clk_gen`

## Requirements
- R1: After reset, `card_clk` is low, `cmd_start` is 0 and `cfg_rdata` is 0.
- R2: `cfg_rdata` returns the last written clock control word with all bits cleared except these three fields: the divider in bits [7:0], the enable in bit 16 and power-save in bit 17.
- R3: Writing the clock control word alone does not change the card clock. The divider and the enable take effect only after an update completes.
- R4: A command write with both bit 31 and bit 21 set makes `cmd_start` read 1 from the next cycle. A command write that lacks either of these bits has no effect.
- R5: When an update is applied, `cmd_start` drops to 0 and `upd_done` is high for exactly one cycle, in the same cycle.
- R6: With the clock enabled, each high phase and each low phase of `card_clk` lasts D module clock cycles, where D is the active divider. The period is therefore 2·D. A divider of 0 behaves as 1.
- R7: If bit 13 was set in the update command, the update waits while `xfer_busy` is high. If bit 13 was clear, the update proceeds while `xfer_busy` is high.
- R8: An update is applied only while `card_clk` is low. A high phase never lasts longer or shorter than the active divider.
- R9: With the active enable at 0, `card_clk` stays low.
- R10: With power-save set and `xfer_busy` low, `card_clk` is held low once the current high phase has ended. When `xfer_busy` rises again, the clock resumes at the active divider.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the clock control word |
| cfg_wdata | input | 32 | Clock control write data |
| cfg_rdata | output | 32 | Clock control readback (pending values) |
| cmd_wr | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Command write data; bits 31, 21 and 13 are decoded |
| cmd_start | output | 1 | Readback of the self-clearing start bit |
| xfer_busy | input | 1 | High while a command or data transfer is active |
| upd_done | output | 1 | One-cycle update completion event |
| card_clk | output | 1 | Divided and gated card clock |

## Verification
The assertions take for granted that `xfer_busy` is a synchronous level that changes only at module clock edges. They also assume that the two write strobes are single-cycle pulses sampled on the rising edge. The stimulus meets both assumptions: every input is driven one nanosecond after a rising edge, and each write strobe is held for exactly one cycle. Random dividers are kept in the range 0 to 9 so that each phase measurement stays short. Busy and power-save changes are made only between updates, apart from the directed cases that deliberately hold an update behind a busy transfer.

// File: rtl/card_clk_gen.sv
module card_clk_gen #(
  parameter int DIV_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_wdata,
  output logic        cmd_start,
  input  logic        xfer_busy,
  output logic        upd_done,
  output logic        card_clk
);
  localparam int EN_BIT   = 16;
  localparam int PS_BIT   = 17;
  localparam int GO_BIT   = 31;
  localparam int UPD_BIT  = 21;
  localparam int WAIT_BIT = 13;

  logic [DIV_W-1:0] pend_div, act_div, cnt, half;
  logic pend_en, psave, act_en, wait_q, card_q, start_q, done_q;
  logic upd_req, apply, run, terminal;
  logic unused_bits;

  assign upd_req  = cmd_wr && cmd_wdata[GO_BIT] && cmd_wdata[UPD_BIT] && !start_q;
  assign apply    = start_q && !(wait_q && xfer_busy) && !card_q;
  assign half     = (act_div == '0) ? DIV_W'(1) : act_div;
  assign terminal = (cnt == half - DIV_W'(1));
  assign run      = act_en && (!psave || xfer_busy);

  assign unused_bits = ^{cfg_wdata[31:PS_BIT+1], cfg_wdata[EN_BIT-1:DIV_W],
                         cmd_wdata[30:UPD_BIT+1], cmd_wdata[UPD_BIT-1:WAIT_BIT+1],
                         cmd_wdata[WAIT_BIT-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_div <= '0;
      pend_en  <= 1'b0;
      psave    <= 1'b0;
    end else if (cfg_wr) begin
      pend_div <= cfg_wdata[DIV_W-1:0];
      pend_en  <= cfg_wdata[EN_BIT];
      psave    <= cfg_wdata[PS_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      wait_q  <= 1'b0;
      done_q  <= 1'b0;
      act_div <= '0;
      act_en  <= 1'b0;
    end else begin
      done_q <= apply;
      if (upd_req) begin
        start_q <= 1'b1;
        wait_q  <= cmd_wdata[WAIT_BIT];
      end else if (apply) begin
        start_q <= 1'b0;
        act_div <= pend_div;
        act_en  <= pend_en;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      card_q <= 1'b0;
    end else if (apply) begin
      cnt <= '0;
    end else if (card_q || run) begin
      if (terminal) begin
        cnt    <= '0;
        card_q <= !card_q;
      end else begin
        cnt <= cnt + DIV_W'(1);
      end
    end else begin
      cnt <= '0;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    cfg_rdata[DIV_W-1:0] = pend_div;
    cfg_rdata[EN_BIT]    = pend_en;
    cfg_rdata[PS_BIT]    = psave;
  end

  assign cmd_start = start_q;
  assign upd_done  = done_q;
  assign card_clk  = card_q;
endmodule

// File: rtl/card_clk_gen_chk.sv
module card_clk_gen_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_wr,
  input logic             go_bit,
  input logic             upd_bit,
  input logic             xfer_busy,
  input logic             cmd_start,
  input logic             upd_done,
  input logic             card_clk,
  input logic             wait_q,
  input logic             act_en,
  input logic             psave,
  input logic [DIV_W-1:0] act_div
);
  logic [DIV_W:0]   hi_len;
  logic [DIV_W-1:0] h;

  assign h = (act_div == '0) ? DIV_W'(1) : act_div;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_len <= '0;
    else        hi_len <= card_clk ? hi_len + 1'b1 : '0;
  end

  p_start_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_start) |-> $past(cmd_wr && go_bit && upd_bit));

  p_clear_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_start) |-> upd_done);

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |=> !upd_done);

  p_hold_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start && wait_q && xfer_busy |=> cmd_start);

  p_apply_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |-> !card_clk);

  p_high_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    card_clk |-> (hi_len < (DIV_W+1)'(h)));

  p_off_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !act_en && !card_clk |=> !card_clk);

  p_psave_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    psave && !xfer_busy && !card_clk |=> !card_clk);
endmodule

bind card_clk_gen card_clk_gen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_wr    (cmd_wr),
  .go_bit    (cmd_wdata[31]),
  .upd_bit   (cmd_wdata[21]),
  .xfer_busy (xfer_busy),
  .cmd_start (cmd_start),
  .upd_done  (upd_done),
  .card_clk  (card_clk),
  .wait_q    (wait_q),
  .act_en    (act_en),
  .psave     (psave),
  .act_div   (act_div)
);

// File: tb/test_card_clk_gen.sv
module test_card_clk_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        cmd_wr = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic        cmd_start;
  logic        xfer_busy = 1'b0;
  logic        upd_done;
  logic        card_clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  localparam logic [31:0] UPD_WAIT   = 32'h8020_2000;
  localparam logic [31:0] UPD_NOWAIT = 32'h8020_0000;

  always #2 clk = ~clk;

  card_clk_gen i_card_clk_gen (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .cmd_start(cmd_start), .xfer_busy(xfer_busy), .upd_done(upd_done),
    .card_clk(card_clk)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      errors++;
      $display("FAIL R5 watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic int exp_half(int d);
    return (d == 0) ? 1 : d;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr_cfg(int d, bit en, bit ps);
    @(posedge clk); #1;
    cfg_wr = 1'b1;
    cfg_wdata = {14'b0, ps, en, 8'b0, 8'(d)};
    @(posedge clk); #1;
    cfg_wr = 1'b0;
  endtask

  task automatic wr_cmd(logic [31:0] w);
    @(posedge clk); #1;
    cmd_wr = 1'b1;
    cmd_wdata = w;
    @(posedge clk); #1;
    cmd_wr = 1'b0;
  endtask

  task automatic wait_clear();
    int n = 0;
    while (cmd_start && n < 600) begin
      @(negedge clk);
      n++;
    end
    chk(!cmd_start, "R5", "start self-clear", cmd_start, 0);
    chk(upd_done, "R5", "done with clear", upd_done, 1);
    chk(!card_clk, "R8", "card low at apply", card_clk, 0);
    @(negedge clk);
    chk(!upd_done, "R5", "done one cycle", upd_done, 0);
  endtask

  task automatic do_update(logic [31:0] w);
    wr_cmd(w);
    @(negedge clk);
    chk(cmd_start, "R4", "start readback", cmd_start, 1);
    wait_clear();
  endtask

  task automatic measure(int h, string req);
    int n = 0;
    int hi = 0;
    int lo = 0;
    @(negedge clk);
    while (card_clk && n < 300) begin @(negedge clk); n++; end
    while (!card_clk && n < 300) begin @(negedge clk); n++; end
    while (card_clk && hi < 300) begin hi++; @(negedge clk); end
    while (!card_clk && lo < 300) begin lo++; @(negedge clk); end
    chk(hi == h, req, "high phase length", hi, h);
    chk(lo == h, req, "low phase length", lo, h);
  endtask

  task automatic hold_low(int cycles, string req);
    bit bad = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (card_clk) bad = 1;
    end
    chk(!bad, req, "card clock held low", bad, 0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(card_clk == 1'b0, "R1", "reset card_clk", card_clk, 0);
    chk(cmd_start == 1'b0, "R1", "reset start", cmd_start, 0);
    chk(cfg_rdata == 32'h0, "R1", "reset readback", cfg_rdata, 0);
    @(posedge clk); #1 rst_n = 1'b1;

    @(posedge clk); #1;
    cfg_wr = 1'b1; cfg_wdata = 32'hFFFF_FFFF;
    @(posedge clk); #1 cfg_wr = 1'b0;
    chk(cfg_rdata == 32'h0003_00FF, "R2", "masked readback", cfg_rdata, 32'h0003_00FF);
    wr_cfg(3, 1'b1, 1'b0);
    chk(cfg_rdata == 32'h0001_0003, "R2", "field readback", cfg_rdata, 32'h0001_0003);
    hold_low(20, "R3");

    wr_cmd(32'h8000_2000);
    @(negedge clk);
    chk(!cmd_start, "R4", "no update bit ignored", cmd_start, 0);
    wr_cmd(32'h0020_2000);
    @(negedge clk);
    chk(!cmd_start, "R4", "no start bit ignored", cmd_start, 0);

    do_update(UPD_WAIT);
    measure(3, "R6");
    wr_cfg(5, 1'b1, 1'b0);
    measure(3, "R3");
    do_update(UPD_WAIT);
    measure(5, "R6");
    wr_cfg(0, 1'b1, 1'b0);
    do_update(UPD_WAIT);
    measure(1, "R6");

    // R7: update held while a transfer is active
    @(posedge clk); #1 xfer_busy = 1'b1;
    wr_cfg(2, 1'b1, 1'b0);
    wr_cmd(UPD_WAIT);
    begin
      bit dropped = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (!cmd_start) dropped = 1;
      end
      chk(!dropped, "R7", "start held while busy", dropped, 0);
    end
    measure(1, "R7");
    @(posedge clk); #1 xfer_busy = 1'b0;
    @(negedge clk);
    wait_clear();
    measure(2, "R7");
    @(posedge clk); #1 xfer_busy = 1'b1;
    wr_cfg(4, 1'b1, 1'b0);
    do_update(UPD_NOWAIT);
    measure(4, "R7");
    @(posedge clk); #1 xfer_busy = 1'b0;

    wr_cfg(4, 1'b0, 1'b0);
    do_update(UPD_WAIT);
    hold_low(30, "R9");

    wr_cfg(2, 1'b1, 1'b1);
    do_update(UPD_WAIT);
    hold_low(30, "R10");
    @(posedge clk); #1 xfer_busy = 1'b1;
    measure(2, "R10");
    @(posedge clk); #1 xfer_busy = 1'b0;
    repeat (4) @(negedge clk);
    hold_low(30, "R10");
    wr_cfg(2, 1'b1, 1'b0);

    for (int k = 0; k < 25; k++) begin
      int d = $urandom_range(0, 9);
      if ($urandom_range(0, 1) == 1) wr_cfg($urandom_range(0, 255), 1'b1, 1'b0);
      wr_cfg(d, 1'b1, 1'b0);
      chk(cfg_rdata == {14'b0, 2'b01, 8'b0, 8'(d)}, "R2", "random readback",
          cfg_rdata, {14'b0, 2'b01, 8'b0, 8'(d)});
      do_update(UPD_WAIT);
      measure(exp_half(d), "R6");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule